// File: doc/BRIEF.md
# Privileged Access Guard

This block sits in the data translation path, next to the baseline permission checker. Each request carries the requesting privilege level, the guard state bit, a flag saying the feature is built in, the page permission bits, the access kind and two flags for cache maintenance. The baseline checker's grant comes in with the request, and this block may only remove it.

While the guard bit is set, a data access made from the kernel level (1) or the hypervisor level (2) to a page that user code (level 0) can reach is refused. Instruction fetches are never refused. Cache-maintenance operations are exempt as well, except the block-zeroing operation, which writes data and is therefore checked. The verdict is registered and appears one cycle after the request. The fault code has two bits, so a baseline denial can be told apart from a refusal by this guard.

Top module: `priv_guard`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs are 0 after that edge.
- R2: A request with `req_valid` high at edge N gives `rsp_valid` high after edge N. With `req_valid` low, all outputs are 0 after the edge.
- R3: A request at level 0 or level 3 (`req_level` holds the level number) never sets the guard-veto fault bit.
- R4: The guard vetoes only when `feat_on`, `guard_bit` and bit 0 of `page_ap` (the page is reachable at level 0) are all 1.
- R5: An access of kind fetch (`acc_kind` = 2) is never vetoed. Read (0), write (1) and the spare code 3 count as data accesses.
- R6: A request with `is_maint` set is exempt unless `is_zero_op` is also set. In that case it is checked like a data write.
- R7: `rsp_denied` equals NOT `base_grant` OR veto for the request answered, so a veto overrides a baseline grant.
- R8: `rsp_fault` bit 1 is the guard veto and bit 0 is the baseline denial. The two bits are independent, and both can be 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_level | input | 2 | Privilege level of the request (0..3) |
| guard_bit | input | 1 | Guard state bit of the processor state |
| feat_on | input | 1 | Feature is built in |
| page_ap | input | 2 | Page access-permission bits; bit 0 set means reachable at level 0 |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 spare (treated as data) |
| is_maint | input | 1 | Request is a cache-maintenance operation |
| is_zero_op | input | 1 | Maintenance request is the block-zeroing operation |
| base_grant | input | 1 | Grant from the baseline permission checker |
| rsp_valid | output | 1 | Verdict valid |
| rsp_denied | output | 1 | Access refused |
| rsp_fault | output | 2 | Bit 1 guard veto, bit 0 baseline denial |

## Verification
A baseline denial and a guard veto can arise for the same request, and that request then sets both fault bits in one verdict. The bench sweeps every combination of level, guard bit, feature flag, permission bits, access kind, maintenance flags and baseline grant, which includes every case where a refused grant meets a qualifying guarded access. For each request it computes both fault bits separately and checks each bit and the denied flag against that result.

// File: rtl/pg_pkg.sv
package pg_pkg;

    localparam int LVL_W  = 2;
    localparam int KIND_W = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_APP    = 2'd0,
        LVL_KERNEL = 2'd1,
        LVL_HYP    = 2'd2,
        LVL_MON    = 2'd3
    } level_e;

    typedef enum logic [KIND_W-1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_SPARE = 2'd3
    } acc_e;

    typedef struct packed {
        logic guard_veto;
        logic base_deny;
    } fault_t;

    typedef struct packed {
        logic   valid;
        logic   denied;
        fault_t fault;
    } resp_t;

    // Only the two middle privilege levels fall under the guard
    function automatic logic level_guarded(level_e lvl);
        return (lvl == LVL_KERNEL) || (lvl == LVL_HYP);
    endfunction

    // Data accesses are checked; fetches never; maintenance only when zeroing
    function automatic logic access_guarded(acc_e kind, logic maint, logic zero);
        return (kind != ACC_FETCH) && (!maint || zero);
    endfunction

endpackage

// File: rtl/pg_scope.sv
module pg_scope
    import pg_pkg::*;
(
    input  level_e lvl,
    input  acc_e   kind,
    input  logic   maint,
    input  logic   zero,
    output logic   in_scope
);
    logic lvl_hit;
    logic acc_hit;

    always_comb begin
        lvl_hit  = level_guarded(lvl);
        acc_hit  = access_guarded(kind, maint, zero);
        in_scope = lvl_hit && acc_hit;
    end
endmodule

// File: rtl/pg_veto_core.sv
module pg_veto_core #(
    parameter int AP_W        = 2,
    parameter int USER_AP_BIT = 0
) (
    input  logic            in_scope,
    input  logic            feat_on,
    input  logic            guard_bit,
    input  logic [AP_W-1:0] page_ap,
    output logic            veto
);
    logic user_page;
    logic unused_ap;

    always_comb begin
        user_page = page_ap[USER_AP_BIT];
        unused_ap = ^page_ap;
        veto      = in_scope && feat_on && guard_bit && user_page;
    end
endmodule

// File: rtl/pg_resp_stage.sv
module pg_resp_stage
    import pg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  logic  base_grant,
    input  logic  veto,
    output resp_t resp
);
    fault_t nxt_fault;

    always_comb begin
        nxt_fault.guard_veto = veto;
        nxt_fault.base_deny  = !base_grant;
    end

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            resp <= '0;
        end else begin
            resp.valid  <= 1'b1;
            resp.denied <= nxt_fault.guard_veto || nxt_fault.base_deny;
            resp.fault  <= nxt_fault;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (resp == '0)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (resp == '0)); // R2
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp.valid); // R2
    AST_BASE_DENY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !base_grant) |=> (resp.denied && resp.fault.base_deny)); // R8
    AST_VETO_WINS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && veto) |=> (resp.denied && resp.fault.guard_veto)); // R7
endmodule

// File: rtl/priv_guard.sv
module priv_guard
    import pg_pkg::*;
#(
    parameter int AP_W        = 2,
    parameter int USER_AP_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [LVL_W-1:0]  req_level,
    input  logic              guard_bit,
    input  logic              feat_on,
    input  logic [AP_W-1:0]   page_ap,
    input  logic [KIND_W-1:0] acc_kind,
    input  logic              is_maint,
    input  logic              is_zero_op,
    input  logic              base_grant,
    output logic              rsp_valid,
    output logic              rsp_denied,
    output logic [1:0]        rsp_fault
);
    level_e lvl;
    acc_e   kind;
    logic   in_scope;
    logic   veto;
    resp_t  resp;

    always_comb begin
        lvl  = level_e'(req_level);
        kind = acc_e'(acc_kind);
    end

    pg_scope u_scope (
        .lvl      (lvl),
        .kind     (kind),
        .maint    (is_maint),
        .zero     (is_zero_op),
        .in_scope (in_scope)
    );

    pg_veto_core #(.AP_W(AP_W), .USER_AP_BIT(USER_AP_BIT)) u_veto (
        .in_scope  (in_scope),
        .feat_on   (feat_on),
        .guard_bit (guard_bit),
        .page_ap   (page_ap),
        .veto      (veto)
    );

    pg_resp_stage u_resp (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .base_grant (base_grant),
        .veto       (veto),
        .resp       (resp)
    );

    always_comb begin
        rsp_valid  = resp.valid;
        rsp_denied = resp.denied;
        rsp_fault  = resp.fault;
    end

    AST_LEVEL_SAFE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_level == 2'd0 || req_level == 2'd3)) |=> !rsp_fault[1]); // R3
    AST_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(feat_on && guard_bit && page_ap[USER_AP_BIT])) |=> !rsp_fault[1]); // R4
    AST_FETCH_SAFE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_kind == 2'd2) |=> !rsp_fault[1]); // R5
    AST_MAINT_EXEMPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_maint && !is_zero_op) |=> !rsp_fault[1]); // R6
    AST_DENY_CONSIST: assert property (@(posedge clk) disable iff (rst)
        rsp_denied == (rsp_fault != 2'b00)); // R7
endmodule

// File: tb/priv_guard_bench.sv
module priv_guard_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_level = '0;
    logic       guard_bit = 1'b0;
    logic       feat_on = 1'b0;
    logic [1:0] page_ap = '0;
    logic [1:0] acc_kind = '0;
    logic       is_maint = 1'b0;
    logic       is_zero_op = 1'b0;
    logic       base_grant = 1'b0;
    logic       rsp_valid;
    logic       rsp_denied;
    logic [1:0] rsp_fault;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_guard u_priv_guard (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
        .guard_bit(guard_bit), .feat_on(feat_on), .page_ap(page_ap),
        .acc_kind(acc_kind), .is_maint(is_maint), .is_zero_op(is_zero_op),
        .base_grant(base_grant), .rsp_valid(rsp_valid),
        .rsp_denied(rsp_denied), .rsp_fault(rsp_fault)
    );

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic exp_veto;
        logic exp_base;
        logic [3:0] exp_all;
        // R1: reset state, even with a request present
        req_valid = 1'b1;
        base_grant = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {rsp_valid, rsp_denied, rsp_fault}, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 idle", {rsp_valid, rsp_denied, rsp_fault}, 4'b0000);

        // Exhaustive sweep, back to back requests
        for (int i = 0; i < 2048; i++) begin
            req_level  = 2'(i);
            acc_kind   = 2'(i >> 2);
            page_ap    = 2'(i >> 4);
            guard_bit  = 1'((i >> 6) & 1);
            feat_on    = 1'((i >> 7) & 1);
            is_maint   = 1'((i >> 8) & 1);
            is_zero_op = 1'((i >> 9) & 1);
            base_grant = 1'((i >> 10) & 1);
            req_valid  = 1'b1;
            exp_veto = (req_level == 2'd1 || req_level == 2'd2)
                     && feat_on && guard_bit && page_ap[0]
                     && (acc_kind != 2'd2) && (!is_maint || is_zero_op);
            exp_base = !base_grant;
            exp_all  = {1'b1, exp_veto | exp_base, exp_veto, exp_base};
            @(negedge clk);
            // R3 R4 R5 R6 R7 R8 all judged by this computed verdict
            if (req_level == 2'd0 || req_level == 2'd3)
                check("R3", {rsp_valid, rsp_denied, rsp_fault}, exp_all);
            else if (acc_kind == 2'd2)
                check("R5", {rsp_valid, rsp_denied, rsp_fault}, exp_all);
            else if (is_maint)
                check("R6", {rsp_valid, rsp_denied, rsp_fault}, exp_all);
            else if (exp_veto && exp_base)
                check("R8", {rsp_valid, rsp_denied, rsp_fault}, exp_all);
            else if (exp_veto)
                check("R7", {rsp_valid, rsp_denied, rsp_fault}, exp_all);
            else
                check("R4", {rsp_valid, rsp_denied, rsp_fault}, exp_all);
        end

        // R2: dropping valid clears the outputs on the next edge
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 drop", {rsp_valid, rsp_denied, rsp_fault}, 4'b0000);

        // R1: reset in mid-stream clears a pending refusal
        req_valid = 1'b1;
        req_level = 2'd1; feat_on = 1'b1; guard_bit = 1'b1; page_ap = 2'b01;
        acc_kind = 2'd1; is_maint = 1'b0; base_grant = 1'b0;
        @(negedge clk);
        check("R8 both", {rsp_valid, rsp_denied, rsp_fault}, 4'b1111);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid", {rsp_valid, rsp_denied, rsp_fault}, 4'b0000);
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule